// File: doc/BRIEF.md
# Byte-Parallel FPGA Configuration Streamer

This block loads a target FPGA through its byte-wide configuration port. On a start pulse it holds the target's active-low program line low for a fixed number of cycles and then releases it. It then waits for the target's active-low init line to read high, which means the target has cleared its configuration memory. After that it writes a fixed eight-byte header to the port.

The configuration image arrives from a byte source over a valid/ready handshake. The image is cut into frames of `FRAME_LEN` bytes. Each frame is written with a sync byte in front and a check byte behind it. The target's pins are sampled before each frame, and frame output stops as soon as init drops or done rises. A fixed trailer follows, whether or not every frame was sent.

At the end the block reports either success or failure on two status outputs, which hold their value until the next start. Every byte written to the port is a one-cycle strobe, and successive strobes are spaced at least `SPACING` clock cycles apart.

Top module: `cfg_streamer_top`

## Requirements
- R1: After reset, `busy`, `done_ok`, `error`, `cfg_strobe` and `src_ready` are 0 and `prog_n` is 1.
- R2: A `start` pulse seen while idle drives `prog_n` low for exactly `PROG_LOW_CYC` cycles, after which it returns high. A `start` seen while busy is ignored and produces no second low pulse.
- R3: No byte is strobed until `init_n` is sampled high after `prog_n` returns high. The first strobe appears two cycles after `init_n` goes high. If `init_n` stays low for `INIT_TIMEOUT` cycles, the run ends with `error` set and no byte written.
- R4: The first eight bytes written are, in order, 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B. The first byte is a dummy that the target discards.
- R5: Each frame is the sync byte 0x4F, then the next `FRAME_LEN` source bytes in arrival order, then the check byte 0x4B.
- R6: A frame begins only if, at its start, `init_n` is 1, `done_pin` is 0 and fewer than `FRAMES` frames have been sent. Otherwise frame output ends and the trailer begins.
- R7: The trailer is nine bytes: 0xFF, 0x4B, then seven bytes of 0xFF.
- R8: Completion is tested in the cycle after the last trailer byte is committed. If all `FRAMES` frames were sent and `done_pin` is 1, `done_ok` is set; otherwise `error` is set. The two are never 1 together, and both hold until the next accepted `start`.
- R9: `cfg_strobe` is high for single cycles only, and two strobes are never closer than `SPACING` cycles.
- R10: A source byte is taken only in a cycle where both `src_valid` and `src_ready` are high. `src_ready` is raised only while frame data is wanted. Gaps in `src_valid` delay the stream but do not change its bytes, and exactly `FRAME_LEN` bytes are taken for each frame sent.
- R11: `busy` is 1 from the cycle after an accepted `start` until the status is set. In the first busy cycle, `done_ok` and `error` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| init_n | input | 1 | Target init line, low while the target is not ready |
| done_pin | input | 1 | Target done line, high once configuration is complete |
| prog_n | output | 1 | Target program line, held low to reset the target |
| cfg_strobe | output | 1 | One-cycle write strobe for the configuration port |
| cfg_data | output | 8 | Byte presented with `cfg_strobe` |
| src_valid | input | 1 | Image source has a byte |
| src_data | input | 8 | Image byte |
| src_ready | output | 1 | Block takes the image byte this cycle if valid |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load succeeded |
| error | output | 1 | Last load failed |

## Verification
The bench sweeps the frame at which the target drops init or raises done through every frame position, including before the first frame. A design that checked the pins only once, or too late, would send extra frames. One that skipped the trailer on abort, or reported success with frames missing, would also be caught. Runs with gaps in the source's valid signal catch a design that duplicates or drops bytes across stalls. Other runs cover an init line that never rises, which would otherwise hang the load, and a second start during a load, which must not re-pulse the program line. Exact cycle checks on the program pulse width, on the first strobe after init release, and on the timeout expiry catch off-by-one counters.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_LOW,
        HS_WAIT
    } cfgs_hs_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_HDR,
        ST_PRE,
        ST_DATA,
        ST_CHK,
        ST_TRL,
        ST_FIN
    } cfgs_state_e;

    typedef struct packed {
        logic       fire;
        logic [7:0] data;
    } cfgs_emit_t;

    localparam logic [7:0] SYNC_BYTE  = 8'h4F;
    localparam logic [7:0] CHECK_BYTE = 8'h4B;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;

    localparam int HDR_LEN = 8;
    localparam int TRL_LEN = 9;

    // Fixed lead-in written before the first frame
    function automatic logic [7:0] hdr_byte(input logic [3:0] i);
        case (i)
            4'd3:    return SYNC_BYTE;
            4'd4:    return 8'h80;
            4'd5:    return 8'hAF;
            4'd6:    return 8'h9B;
            4'd7:    return CHECK_BYTE;
            default: return FILL_BYTE;
        endcase
    endfunction

    // Fixed tail written after the last frame
    function automatic logic [7:0] trl_byte(input logic [3:0] i);
        return (i == 4'd1) ? CHECK_BYTE : FILL_BYTE;
    endfunction

endpackage

// File: rtl/cfgs_pin_hs.sv
module cfgs_pin_hs
    import cfgs_pkg::*;
#(
    parameter int PROG_LOW_CYC = 25,
    parameter int INIT_TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic init_n,
    output logic prog_n,
    output logic init_seen,
    output logic init_lost
);
    localparam int PW = $clog2(PROG_LOW_CYC + 1);
    localparam int TW = $clog2(INIT_TIMEOUT + 1);

    cfgs_hs_e        hs_st;
    logic [PW-1:0]   low_cnt;
    logic [TW-1:0]   wait_cnt;
    logic            wait_last;

    assign wait_last = (wait_cnt == TW'(INIT_TIMEOUT - 1));
    assign prog_n    = (hs_st != HS_LOW);
    assign init_seen = (hs_st == HS_WAIT) && init_n;
    assign init_lost = (hs_st == HS_WAIT) && !init_n && wait_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_st    <= HS_IDLE;
            low_cnt  <= '0;
            wait_cnt <= '0;
        end else begin
            case (hs_st)
                HS_IDLE: begin
                    if (kick) begin
                        hs_st   <= HS_LOW;
                        low_cnt <= PW'(PROG_LOW_CYC - 1);
                    end
                end
                HS_LOW: begin
                    if (low_cnt == '0) begin
                        hs_st    <= HS_WAIT;
                        wait_cnt <= '0;
                    end else begin
                        low_cnt <= low_cnt - 1'b1;
                    end
                end
                HS_WAIT: begin
                    if (init_n || wait_last) begin
                        hs_st <= HS_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: hs_st <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgs_pacer.sv
module cfgs_pacer #(
    parameter int SPACING = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic slot_ok
);
    localparam int CW = (SPACING > 1) ? $clog2(SPACING) : 1;

    logic [CW-1:0] gap_cnt;

    assign slot_ok = (gap_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
        end else if (fire) begin
            gap_cnt <= CW'(SPACING - 1);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cfgs_seq.sv
module cfgs_seq
    import cfgs_pkg::*;
#(
    parameter int FRAME_LEN = 21,
    parameter int FRAMES    = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       init_seen,
    input  logic       init_lost,
    input  logic       init_n,
    input  logic       done_pin,
    input  logic       slot_ok,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       kick,
    output logic       fire,
    output logic       src_ready,
    output logic       cfg_strobe,
    output logic [7:0] cfg_data,
    output logic       busy,
    output logic       done_ok,
    output logic       error
);
    localparam int IMAX = (FRAME_LEN > TRL_LEN) ? FRAME_LEN : TRL_LEN;
    localparam int IW   = ($clog2(IMAX + 1) > 4) ? $clog2(IMAX + 1) : 4;
    localparam int FW   = $clog2(FRAMES + 1);

    cfgs_state_e   state;
    logic [IW-1:0] idx;
    logic [FW-1:0] frames_left;
    logic          frame_go;
    cfgs_emit_t    emit;

    assign kick      = (state == ST_IDLE) && start;
    assign busy      = (state != ST_IDLE);
    assign src_ready = (state == ST_DATA) && slot_ok;
    assign frame_go  = init_n && !done_pin && (frames_left != '0);
    assign fire      = emit.fire;

    always_comb begin
        emit = '{fire: 1'b0, data: FILL_BYTE};
        case (state)
            ST_HDR:  emit = '{fire: slot_ok, data: hdr_byte(idx[3:0])};
            ST_PRE:  emit = '{fire: slot_ok && frame_go, data: SYNC_BYTE};
            ST_DATA: emit = '{fire: slot_ok && src_valid, data: src_data};
            ST_CHK:  emit = '{fire: slot_ok, data: CHECK_BYTE};
            ST_TRL:  emit = '{fire: slot_ok, data: trl_byte(idx[3:0])};
            default: emit = '{fire: 1'b0, data: FILL_BYTE};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_strobe <= 1'b0;
            cfg_data   <= '0;
        end else begin
            cfg_strobe <= emit.fire;
            if (emit.fire) cfg_data <= emit.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            idx         <= '0;
            frames_left <= '0;
            done_ok     <= 1'b0;
            error       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_PROG;
                        done_ok     <= 1'b0;
                        error       <= 1'b0;
                        frames_left <= FW'(FRAMES);
                        idx         <= '0;
                    end
                end
                ST_PROG: begin
                    if (init_seen) begin
                        state <= ST_HDR;
                        idx   <= '0;
                    end else if (init_lost) begin
                        state <= ST_IDLE;
                        error <= 1'b1;
                    end
                end
                ST_HDR: begin
                    if (emit.fire) begin
                        if (idx == IW'(HDR_LEN - 1)) begin
                            state <= ST_PRE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_PRE: begin
                    if (slot_ok) begin
                        state <= frame_go ? ST_DATA : ST_TRL;
                        idx   <= '0;
                    end
                end
                ST_DATA: begin
                    if (emit.fire) begin
                        if (idx == IW'(FRAME_LEN - 1)) begin
                            state <= ST_CHK;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_CHK: begin
                    if (emit.fire) begin
                        state       <= ST_PRE;
                        frames_left <= frames_left - 1'b1;
                    end
                end
                ST_TRL: begin
                    if (emit.fire) begin
                        if (idx == IW'(TRL_LEN - 1)) begin
                            state <= ST_FIN;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    if ((frames_left == '0) && done_pin) done_ok <= 1'b1;
                    else                                 error   <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_streamer_top.sv
module cfg_streamer_top #(
    parameter int FRAME_LEN    = 21,
    parameter int FRAMES       = 1024,
    parameter int PROG_LOW_CYC = 25,
    parameter int INIT_TIMEOUT = 100000,
    parameter int SPACING      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       init_n,
    input  logic       done_pin,
    output logic       prog_n,
    output logic       cfg_strobe,
    output logic [7:0] cfg_data,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       src_ready,
    output logic       busy,
    output logic       done_ok,
    output logic       error
);
    logic kick;
    logic init_seen;
    logic init_lost;
    logic slot_ok;
    logic fire;

    cfgs_pin_hs #(
        .PROG_LOW_CYC (PROG_LOW_CYC),
        .INIT_TIMEOUT (INIT_TIMEOUT)
    ) u_pin_hs (
        .clk       (clk),
        .rst       (rst),
        .kick      (kick),
        .init_n    (init_n),
        .prog_n    (prog_n),
        .init_seen (init_seen),
        .init_lost (init_lost)
    );

    cfgs_pacer #(
        .SPACING (SPACING)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .slot_ok (slot_ok)
    );

    cfgs_seq #(
        .FRAME_LEN (FRAME_LEN),
        .FRAMES    (FRAMES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .init_seen  (init_seen),
        .init_lost  (init_lost),
        .init_n     (init_n),
        .done_pin   (done_pin),
        .slot_ok    (slot_ok),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .kick       (kick),
        .fire       (fire),
        .src_ready  (src_ready),
        .cfg_strobe (cfg_strobe),
        .cfg_data   (cfg_data),
        .busy       (busy),
        .done_ok    (done_ok),
        .error      (error)
    );
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
    parameter int SPACING = 4
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic prog_n,
    input logic cfg_strobe,
    input logic src_ready,
    input logic busy,
    input logic done_ok,
    input logic error
);
    int since_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_strobe <= SPACING;
        end else if (cfg_strobe) begin
            since_strobe <= 1;
        end else if (since_strobe < SPACING) begin
            since_strobe <= since_strobe + 1;
        end
    end

    // R2: no byte written while the target is held in reset
    p_quiet_in_prog_r2: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> (!cfg_strobe && busy));

    // R9: strobes never closer than SPACING cycles
    p_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_strobe |-> (since_strobe >= SPACING));

    // R10: source is only asked for data during a load with program released
    p_ready_in_load_r10: assert property (@(posedge clk) disable iff (rst)
        src_ready |-> (busy && prog_n));

    // R8: success and failure are exclusive
    p_status_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && error));

    // R8: status holds while idle and no start arrives
    p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(done_ok) && $stable(error)));

    // R11: status is cleared in the first busy cycle
    p_clear_on_start_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!done_ok && !error));
endmodule

bind cfg_streamer_top cfgs_checker #(
    .SPACING (SPACING)
) u_cfgs_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .prog_n     (prog_n),
    .cfg_strobe (cfg_strobe),
    .src_ready  (src_ready),
    .busy       (busy),
    .done_ok    (done_ok),
    .error      (error)
);

// File: tb/cfg_streamer_top_tb_top.sv
module cfg_streamer_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FL   = 21;
    localparam int NF   = 3;
    localparam int PLOW = 3;
    localparam int TOUT = 40;
    localparam int SPC  = 2;
    localparam int HDR  = 8;
    localparam int TRL  = 9;
    localparam int FRB  = FL + 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       init_n;
    logic       done_pin;
    logic       src_valid;
    logic [7:0] src_data;
    logic       prog_n;
    logic       cfg_strobe;
    logic [7:0] cfg_data;
    logic       src_ready;
    logic       busy;
    logic       done_ok;
    logic       error;

    cfg_streamer_top #(
        .FRAME_LEN    (FL),
        .FRAMES       (NF),
        .PROG_LOW_CYC (PLOW),
        .INIT_TIMEOUT (TOUT),
        .SPACING      (SPC)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .init_n     (init_n),
        .done_pin   (done_pin),
        .prog_n     (prog_n),
        .cfg_strobe (cfg_strobe),
        .cfg_data   (cfg_data),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_ready  (src_ready),
        .busy       (busy),
        .done_ok    (done_ok),
        .error      (error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit wd     = 1'b0;

    int  init_delay, abort_kind, abort_k, stall_mode;
    bit  done_at_end;
    bit  mon_en = 1'b0;

    logic [7:0] got [0:127];
    int  nstr, last_str_cyc, first_str_cyc, space_bad;
    int  prog_low_cnt, prog_pulses, wait_cnt, rel_cyc;
    bit  prog_prev, init_rel, prog_went_low, hs_pend;
    int  src_idx, hs_cnt;

    function automatic logic [7:0] sdat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] hdr_exp(input int i);
        case (i)
            3: return 8'h4F;
            4: return 8'h80;
            5: return 8'hAF;
            6: return 8'h9B;
            7: return 8'h4B;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) wd = 1'b1;
        if (mon_en) begin
            if (hs_pend) begin
                src_idx++;
                hs_cnt++;
            end
            if (cfg_strobe) begin
                if (nstr < 128) got[nstr] = cfg_data;
                if (nstr > 0 && (cyc - last_str_cyc) < SPC) space_bad++;
                if (nstr == 0) first_str_cyc = cyc;
                last_str_cyc = cyc;
                nstr++;
                if (abort_kind == 1 && nstr == HDR + abort_k * FRB) init_n = 1'b0;
                if (abort_kind == 2 && nstr == HDR + abort_k * FRB) done_pin = 1'b1;
                if (done_at_end && nstr == HDR + NF * FRB) done_pin = 1'b1;
            end
            if (!prog_n) begin
                prog_low_cnt++;
                if (prog_prev) prog_pulses++;
                prog_went_low = 1'b1;
            end else if (prog_went_low && !init_rel) begin
                wait_cnt++;
                if (wait_cnt >= init_delay) begin
                    init_n   = 1'b1;
                    init_rel = 1'b1;
                    rel_cyc  = cyc;
                end
            end
            prog_prev = prog_n;
            src_valid = (stall_mode != 0) ? ((cyc % 3) != 1) : 1'b1;
            src_data  = sdat(src_idx);
            hs_pend   = src_valid && src_ready;
        end
    end

    task automatic launch(input int idl, input int ak, input int k,
                          input bit dend, input int stl, input bit extra_start,
                          output int dur);
        int st;
        int n;
        @(negedge clk);
        init_n = 1'b0; done_pin = 1'b0;
        init_delay = idl; abort_kind = ak; abort_k = k;
        done_at_end = dend; stall_mode = stl;
        nstr = 0; last_str_cyc = 0; first_str_cyc = 0; space_bad = 0;
        prog_low_cnt = 0; prog_pulses = 0; wait_cnt = 0; rel_cyc = 0;
        prog_prev = 1'b1; init_rel = 1'b0; prog_went_low = 1'b0; hs_pend = 1'b0;
        src_idx = 0; hs_cnt = 0;
        mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        st = cyc;
        // R11: busy and cleared status in first cycle after start
        chk(busy === 1'b1, "R11 busy after start", int'(busy), 1);
        chk(done_ok === 1'b0 && error === 1'b0, "R11 status cleared", int'({done_ok, error}), 0);
        n = 0;
        while (busy && !wd) begin
            @(negedge clk);
            start = (extra_start && n == 20) ? 1'b1 : 1'b0;
            n++;
        end
        start = 1'b0;
        dur = cyc - st;
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic run_load(input int idl, input int ak, input int k, input bit dend,
                            input int stl, input bit extra_start,
                            input int exp_frames, input bit exp_ok);
        int dur;
        int hbad, fbad, tbad;
        int exp_n;
        launch(idl, ak, k, dend, stl, extra_start, dur);
        exp_n = HDR + exp_frames * FRB + TRL;
        // R2: one program pulse of exact width
        chk(prog_pulses == 1, "R2 program pulse count", prog_pulses, 1);
        chk(prog_low_cnt == PLOW, "R2 program pulse width", prog_low_cnt, PLOW);
        // R3: first strobe two cycles after init released
        chk(first_str_cyc - rel_cyc == 2, "R3 first strobe delay", first_str_cyc - rel_cyc, 2);
        // R6: number of bytes reflects frames sent
        chk(nstr == exp_n, "R6 byte count", nstr, exp_n);
        hbad = 0; fbad = 0; tbad = 0;
        for (int p = 0; p < nstr && p < exp_n && p < 128; p++) begin
            if (p < HDR) begin
                if (got[p] !== hdr_exp(p)) hbad++;
            end else if (p < HDR + exp_frames * FRB) begin
                int q = p - HDR;
                int f = q / FRB;
                int r = q % FRB;
                logic [7:0] e;
                if (r == 0)            e = 8'h4F;
                else if (r == FRB - 1) e = 8'h4B;
                else                   e = sdat(f * FL + r - 1);
                if (got[p] !== e) fbad++;
            end else begin
                int t = p - HDR - exp_frames * FRB;
                if (got[p] !== ((t == 1) ? 8'h4B : 8'hFF)) tbad++;
            end
        end
        chk(hbad == 0, "R4 header bytes", hbad, 0);
        chk(fbad == 0, "R5 frame bytes", fbad, 0);
        chk(tbad == 0, "R7 trailer bytes", tbad, 0);
        chk(space_bad == 0, "R9 strobe spacing", space_bad, 0);
        chk(hs_cnt == exp_frames * FL, "R10 source bytes taken", hs_cnt, exp_frames * FL);
        chk(done_ok === exp_ok, "R8 done_ok", int'(done_ok), int'(exp_ok));
        chk(error === !exp_ok, "R8 error", int'(error), int'(!exp_ok));
        chk(busy === 1'b0, "R11 busy low after finish", int'(busy), 0);
    endtask

    initial begin
        int dur;
        rst = 1'b1; start = 1'b0; init_n = 1'b0; done_pin = 1'b0;
        src_valid = 1'b0; src_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && done_ok === 1'b0 && error === 1'b0, "R1 status after reset",
            int'({busy, done_ok, error}), 0);
        chk(prog_n === 1'b1, "R1 prog_n after reset", int'(prog_n), 1);
        chk(cfg_strobe === 1'b0 && src_ready === 1'b0, "R1 strobe and ready after reset",
            int'({cfg_strobe, src_ready}), 0);

        // Full load, done rises at end, various init delays
        for (int d = 1; d <= 3; d++) run_load(d * 2 - 1, 0, 0, 1'b1, 0, 1'b0, NF, 1'b1);
        // R10: source stalls do not alter stream
        run_load(4, 0, 0, 1'b1, 1, 1'b0, NF, 1'b1);
        // R8: full load but done never rises
        run_load(2, 0, 0, 1'b0, 0, 1'b0, NF, 1'b0);
        // R6: init drops before frame k
        for (int k = 0; k < NF; k++) run_load(2, 1, k, 1'b0, k % 2, 1'b0, k, 1'b0);
        // R6, R8: done rises early before frame k
        for (int k = 0; k < NF; k++) run_load(3, 2, k, 1'b0, 0, 1'b0, k, 1'b0);
        // R2: second start while busy is ignored
        run_load(2, 0, 0, 1'b1, 0, 1'b1, NF, 1'b1);

        // R3: init never rises -> timeout error with no bytes
        launch(1000000, 0, 0, 1'b0, 0, 1'b0, dur);
        chk(dur == PLOW + TOUT, "R3 timeout expiry cycle", dur, PLOW + TOUT);
        chk(nstr == 0, "R3 no bytes on timeout", nstr, 0);
        chk(error === 1'b1 && done_ok === 1'b0, "R3 error on timeout",
            int'({done_ok, error}), 1);
        chk(prog_low_cnt == PLOW, "R2 program width on timeout run", prog_low_cnt, PLOW);
        repeat (5) @(negedge clk);
        // R8: error held while idle
        chk(error === 1'b1, "R8 error held", int'(error), 1);

        // Error is cleared by the next load which succeeds
        run_load(1, 0, 0, 1'b1, 1, 1'b0, NF, 1'b1);

        if (wd) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (wd);
        repeat (400000) @(negedge clk);
        fails++;
        $display("FAIL watchdog hard stop actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule